// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the bus side of a 1024-byte serial nonvolatile memory that sits on an open-drain two-wire bus. A fast system clock samples the SCL and SDA lines. The block finds start and stop conditions and takes in the device-select byte. When that byte matches, it acknowledges and then either takes a word address followed by data bytes (a write) or streams stored bytes back to the master (a read). It never drives SDA high. It only asserts an output enable that pulls the line low.

The block owns the 10-bit word pointer. Its two upper bits come from the device-select byte and its lower eight bits come from the word-address byte. A simple synchronous memory port stands in for the storage array: a one-cycle write strobe, and a one-cycle read strobe whose data returns on the following cycle. A busy input stands in for a nonvolatile write cycle in progress. While busy is high, the block stays silent on the bus and does nothing.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: After reset, sda_oe, mem_wr and mem_rd are low. The block does not acknowledge any byte that is clocked before a start condition.
- R2: A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. A start at any point, including mid-byte, restarts device-byte reception. A stop returns the block to idle, and later bytes go unacknowledged until the next start.
- R3: The device byte is decoded with bits 7:4 equal to 1010 and bit 3 equal to a2_i. Bits 2:1 are pointer bits 9:8, and bit 0 selects read (1) or write (0). A matching byte is acknowledged by pulling SDA low during the ninth clock. A byte that does not match is not acknowledged, and the bus is then ignored until the next start.
- R4: In a write, the byte after the device byte sets pointer bits 7:0. Each following byte is acknowledged and stored with a single-cycle mem_wr at the pointer, and the pointer then advances by one.
- R5: Read data leaves MSB first. The block changes sda_oe only after a falling SCL edge, whether it is sending an acknowledge or a data bit.
- R6: After each read byte, a master acknowledge (SDA low on the ninth clock) makes the block send the next byte. A missing acknowledge makes it release SDA and stay quiet until a start or stop.
- R7: The pointer advances from 1023 to 0.
- R8: A read with no word-address phase fetches from the pointer's current bits 7:0, joined with bits 2:1 of the device byte. After any read, the pointer rests one past the last byte actually sent.
- R9: While busy_i is high the block gives no acknowledge, drives nothing, issues no mem_wr or mem_rd, and forgets any transfer in progress.
- R10: mem_rd is a single-cycle pulse, and mem_rdata is taken on the cycle after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low |
| a2_i | input | 1 | Strap bit compared with device-byte bit 3 |
| busy_i | input | 1 | Nonvolatile write cycle in progress |
| mem_addr | output | 10 | Memory pointer |
| mem_wr | output | 1 | One-cycle write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rd | output | 1 | One-cycle read strobe |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_rd |

## Verification
Start detection and bit shifting can fall in the same state. A start can arrive while a byte is half shifted in, and it must win over the partial byte. The bench provokes this by clocking four device-byte bits and then issuing a start, followed by a full write. The result is judged by the acknowledges, by the one expected memory write at the new address, and by reading that byte back. A second overlap is busy_i against the falling edge that would begin an acknowledge. The bench holds busy across complete write and read requests and checks that no acknowledge, no memory strobe and no data appear.

// File: rtl/eeprom_slave_pkg.sv
package eeprom_slave_pkg;
  localparam int PAGE_W = 2;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = BYTE_W + PAGE_W;

  typedef logic [ADDR_W-1:0] waddr_t;

  typedef enum logic [2:0] {
    S_IDLE, S_DEV, S_WORD, S_WDATA, S_ACK, S_RDATA, S_RACK, S_HOLD
  } state_t;

  // device byte: [7:4] type code, [3] strap, [2:1] page, [0] direction
  function automatic logic dev_match(input logic [BYTE_W-1:0] b,
                                     input logic [3:0] id, input logic strap);
    return (b[7:4] == id) && (b[3] == strap);
  endfunction

  function automatic waddr_t addr_step(input waddr_t a);
    return a + waddr_t'(1);
  endfunction
endpackage

// File: rtl/eeprom_slave_sync.sv
module eeprom_slave_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) r <= '1;
    else        r <= {r[STAGES-2:0], d};
  end

  assign q = r[STAGES-1];
endmodule

// File: rtl/eeprom_slave_events.sv
module eeprom_slave_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_rise,
  output logic ev_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign ev_rise  =  scl_s & ~scl_q;
  assign ev_fall  = ~scl_s &  scl_q;
  assign ev_start =  scl_s &  scl_q &  sda_q & ~sda_s;
  assign ev_stop  =  scl_s &  scl_q & ~sda_q &  sda_s;
endmodule

// File: rtl/eeprom_slave_addr.sv
module eeprom_slave_addr
  import eeprom_slave_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_page,
  input  logic [PAGE_W-1:0] page,
  input  logic              ld_word,
  input  logic [BYTE_W-1:0] word,
  input  logic              inc,
  output waddr_t            addr
);
  waddr_t addr_nx;

  always_comb begin
    addr_nx = addr;
    if (inc) addr_nx = addr_step(addr);
    if (ld_page) addr_nx[ADDR_W-1:BYTE_W] = page;
    if (ld_word) addr_nx[BYTE_W-1:0] = word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr <= '0;
    else        addr <= addr_nx;
  end

  // R7: the top address rolls over to zero
  a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld_page && !ld_word && addr == '1) |=> addr == '0);
endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
  import eeprom_slave_pkg::*;
#(
  parameter logic [3:0] DEV_ID      = 4'b1010,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              a2_i,
  input  logic              busy_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              mem_rd,
  input  logic [BYTE_W-1:0] mem_rdata
);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  logic scl_s, sda_s;
  logic ev_start, ev_stop, ev_rise, ev_fall;

  eeprom_slave_sync #(.STAGES(SYNC_STAGES)) i_sync_scl (
    .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
  eeprom_slave_sync #(.STAGES(SYNC_STAGES)) i_sync_sda (
    .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

  eeprom_slave_events i_events (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_rise(ev_rise), .ev_fall(ev_fall));

  state_t            state, ack_next;
  logic [BIT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] shreg, txbyte, txsh;
  logic              got_byte, rd_load, acked;

  // named internal events
  logic byte_fall, dev_ok, dev_hit, ld_word, ptr_inc;
  assign byte_fall = !busy_i && ev_fall && got_byte;
  assign dev_ok    = dev_match(shreg, DEV_ID, a2_i);
  assign dev_hit   = byte_fall && state == S_DEV && dev_ok;
  assign ld_word   = byte_fall && state == S_WORD;
  assign ptr_inc   = mem_wr || rd_load;

  waddr_t ptr;
  eeprom_slave_addr i_addr (
    .clk(clk), .rst_n(rst_n),
    .ld_page(dev_hit), .page(shreg[PAGE_W:1]),
    .ld_word(ld_word), .word(shreg),
    .inc(ptr_inc), .addr(ptr));
  assign mem_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; ack_next <= S_IDLE; bitcnt <= '0;
      shreg <= '0; txbyte <= '0; txsh <= '0;
      got_byte <= 1'b0; rd_load <= 1'b0; acked <= 1'b0;
      sda_oe <= 1'b0; mem_wr <= 1'b0; mem_wdata <= '0; mem_rd <= 1'b0;
    end else begin
      mem_wr  <= 1'b0;
      mem_rd  <= 1'b0;
      rd_load <= mem_rd;
      if (rd_load) txbyte <= mem_rdata;
      if (busy_i) begin
        state <= S_IDLE; sda_oe <= 1'b0; got_byte <= 1'b0; acked <= 1'b0;
      end else if (ev_start) begin
        state <= S_DEV; bitcnt <= '0; sda_oe <= 1'b0; got_byte <= 1'b0; acked <= 1'b0;
      end else if (ev_stop) begin
        state <= S_IDLE; sda_oe <= 1'b0; got_byte <= 1'b0; acked <= 1'b0;
      end else begin
        case (state)
          S_DEV, S_WORD, S_WDATA: begin
            if (ev_rise) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + BIT_W'(1);
              if (bitcnt == LAST_BIT) got_byte <= 1'b1;
            end else if (ev_fall && got_byte) begin
              got_byte <= 1'b0;
              case (state)
                S_DEV: begin
                  if (dev_ok) begin
                    sda_oe <= 1'b1;
                    state  <= S_ACK;
                    if (shreg[0]) begin
                      ack_next <= S_RDATA;
                      mem_rd   <= 1'b1;
                    end else begin
                      ack_next <= S_WORD;
                    end
                  end else begin
                    state <= S_IDLE;
                  end
                end
                S_WORD: begin
                  sda_oe <= 1'b1; state <= S_ACK; ack_next <= S_WDATA;
                end
                default: begin
                  sda_oe <= 1'b1; state <= S_ACK; ack_next <= S_WDATA;
                  mem_wr <= 1'b1; mem_wdata <= shreg;
                end
              endcase
            end
          end
          S_ACK: if (ev_fall) begin
            state  <= ack_next;
            bitcnt <= '0;
            if (ack_next == S_RDATA) begin
              sda_oe <= ~txbyte[BYTE_W-1];
              txsh   <= {txbyte[BYTE_W-2:0], 1'b0};
            end else begin
              sda_oe <= 1'b0;
            end
          end
          S_RDATA: if (ev_fall) begin
            if (bitcnt == LAST_BIT) begin
              sda_oe <= 1'b0; state <= S_RACK; bitcnt <= '0;
            end else begin
              sda_oe <= ~txsh[BYTE_W-1];
              txsh   <= {txsh[BYTE_W-2:0], 1'b0};
              bitcnt <= bitcnt + BIT_W'(1);
            end
          end
          S_RACK: begin
            if (ev_rise) begin
              if (!sda_s) begin
                mem_rd <= 1'b1; acked <= 1'b1;
              end else begin
                state <= S_HOLD;
              end
            end else if (ev_fall && acked) begin
              acked  <= 1'b0;
              state  <= S_RDATA;
              bitcnt <= '0;
              sda_oe <= ~txbyte[BYTE_W-1];
              txsh   <= {txbyte[BYTE_W-2:0], 1'b0};
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R9: busy silences the bus side and the memory port
  a_r9_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> (!sda_oe && !mem_wr && !mem_rd));
  // R5: pull-down begins only after a falling SCL edge
  a_r5_drive_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(ev_fall));
  // R2: a start restarts device-byte reception
  a_r2_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start && !busy_i) |=> state == S_DEV);
  // R2: a stop returns to idle and releases SDA
  a_r2_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && !busy_i) |=> (state == S_IDLE && !sda_oe));
  // R4: each stored byte is one strobe
  a_r4_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !mem_wr);
  // R10: read strobe lasts one cycle
  a_r10_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);
  // R6: after a missing master acknowledge the line stays released
  a_r6_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_HOLD |-> !sda_oe);
endmodule

// File: tb/test_eeprom_i2c_slave.sv
`timescale 1ns/1ps
module test_eeprom_i2c_slave;
  localparam int Q = 10;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic a2 = 1'b1, busy = 1'b0;
  logic sda_oe, mem_wr, mem_rd;
  logic [9:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  wire sda_line = sda_m & ~sda_oe;

  eeprom_i2c_slave i_eeprom_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .a2_i(a2), .busy_i(busy), .mem_addr(mem_addr), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_rdata(mem_rdata));

  logic [7:0] mem  [1024];
  logic [7:0] gold [1024];
  logic [17:0] exp_q[$];
  int checks = 0, failures = 0;
  bit done = 0;

  initial begin
    mem_rdata = '0;
    for (int i = 0; i < 1024; i++) begin
      mem[i]  = 8'(i) ^ 8'h3C;
      gold[i] = 8'(i) ^ 8'h3C;
    end
  end

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected writes as the design stores them (R4, R9)
  always @(negedge clk) begin
    if (rst_n && mem_wr) begin
      if (exp_q.size() == 0) chk(0, "R4/R9", "unexpected write", {8'h0, mem_addr}, 0);
      else begin
        logic [17:0] e;
        e = exp_q.pop_front();
        chk({mem_addr, mem_wdata} == e, "R4", "write addr/data", {mem_addr, mem_wdata}, e);
      end
    end
  end

  task automatic expect_wr(input logic [9:0] a, input logic [7:0] d);
    exp_q.push_back({a, d});
    gold[a] = d;
  endtask

  task automatic wq; repeat (Q) @(negedge clk); endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic do_start;
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic do_stop;
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ackd);
    logic r;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(r);
    ackd = ~r;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic master_ack);
    for (int i = 7; i >= 0; i--) get_bit(b[i]);
    put_bit(~master_ack);
  endtask

  function automatic logic [7:0] devb(input logic [1:0] pg, input logic rw);
    return {4'b1010, 1'b1, pg, rw};
  endfunction

  task automatic send_chk(input logic [7:0] b, input logic exp_ack,
                          input string req, input string what);
    logic a;
    send_byte(b, a);
    chk(a == exp_ack, req, what, int'(a), int'(exp_ack));
  endtask

  task automatic recv_chk(input logic master_ack, input logic [7:0] exp,
                          input string req, input string what);
    logic [7:0] v;
    recv_byte(v, master_ack);
    chk(v == exp, req, what, v, exp);
  endtask

  task automatic report;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=expired expected=finished");
    report();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(!sda_oe && !mem_wr && !mem_rd, "R1", "reset outputs",
        {sda_oe, mem_wr, mem_rd}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    scl_m = 1'b0; wq();
    send_chk(devb(2'd1, 1'b0), 1'b0, "R1", "ack before any start");

    // R3/R4 write two bytes at 0x123
    do_start();
    send_chk(devb(2'd1, 1'b0), 1'b1, "R3", "device ack");
    send_chk(8'h23, 1'b1, "R4", "word ack");
    expect_wr(10'h123, 8'hA5);
    send_chk(8'hA5, 1'b1, "R4", "data ack 1");
    expect_wr(10'h124, 8'h5A);
    send_chk(8'h5A, 1'b1, "R4", "data ack 2");
    do_stop();
    chk(exp_q.size() == 0, "R4", "writes consumed", exp_q.size(), 0);

    // R3 mismatches
    do_start();
    send_chk(8'b1011_1010, 1'b0, "R3", "wrong type ack");
    do_stop();
    do_start();
    send_chk(8'b1010_0010, 1'b0, "R3", "wrong strap ack");
    send_chk(8'h00, 1'b0, "R3", "ignored until start");
    do_stop();

    // R5/R6 random read from 0x123
    do_start();
    send_chk(devb(2'd1, 1'b0), 1'b1, "R3", "device ack");
    send_chk(8'h23, 1'b1, "R4", "word ack");
    do_start();
    send_chk(devb(2'd1, 1'b1), 1'b1, "R3", "read device ack");
    recv_chk(1'b1, gold[10'h123], "R5", "read byte 1");
    recv_chk(1'b0, gold[10'h124], "R6", "read byte 2 after ack");
    recv_chk(1'b0, 8'hFF, "R6", "released after no ack");
    do_stop();

    // R8 current-address reads
    do_start();
    send_chk(devb(2'd1, 1'b1), 1'b1, "R8", "current read ack");
    recv_chk(1'b0, gold[10'h125], "R8", "pointer one past last");
    do_stop();
    do_start();
    send_chk(devb(2'd2, 1'b1), 1'b1, "R8", "current read ack page2");
    recv_chk(1'b0, gold[10'h226], "R8", "page bits from device byte");
    do_stop();

    // R7 wrap on write and read
    do_start();
    send_chk(devb(2'd3, 1'b0), 1'b1, "R7", "device ack");
    send_chk(8'hFF, 1'b1, "R7", "word ack");
    expect_wr(10'h3FF, 8'h11);
    send_chk(8'h11, 1'b1, "R7", "data ack top");
    expect_wr(10'h000, 8'h22);
    send_chk(8'h22, 1'b1, "R7", "data ack wrapped");
    do_stop();
    do_start();
    send_chk(devb(2'd3, 1'b0), 1'b1, "R7", "device ack");
    send_chk(8'hFF, 1'b1, "R7", "word ack");
    do_start();
    send_chk(devb(2'd3, 1'b1), 1'b1, "R7", "read ack");
    recv_chk(1'b1, 8'h11, "R7", "read top");
    recv_chk(1'b0, 8'h22, "R7", "read after wrap");
    do_stop();

    // R9 busy
    busy = 1'b1;
    do_start();
    send_chk(devb(2'd0, 1'b0), 1'b0, "R9", "busy device ack");
    send_chk(8'h40, 1'b0, "R9", "busy word ack");
    send_chk(8'h99, 1'b0, "R9", "busy data ack");
    do_stop();
    do_start();
    send_chk(devb(2'd0, 1'b1), 1'b0, "R9", "busy read ack");
    recv_chk(1'b0, 8'hFF, "R9", "busy read data");
    do_stop();
    busy = 1'b0;
    wq();
    chk(mem[10'h040] == gold[10'h040], "R9", "no store while busy", mem[10'h040], gold[10'h040]);

    // R2 start in the middle of a byte
    do_start();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    do_start();
    send_chk(devb(2'd0, 1'b0), 1'b1, "R2", "ack after mid-byte start");
    send_chk(8'h10, 1'b1, "R2", "word ack");
    expect_wr(10'h010, 8'h77);
    send_chk(8'h77, 1'b1, "R2", "data ack");
    do_stop();
    do_start();
    send_chk(devb(2'd0, 1'b0), 1'b1, "R2", "device ack");
    send_chk(8'h10, 1'b1, "R2", "word ack");
    do_start();
    send_chk(devb(2'd0, 1'b1), 1'b1, "R2", "read ack");
    recv_chk(1'b0, 8'h77, "R2", "read back");
    do_stop();

    // R2 stop mid write leaves the bus ignored
    do_start();
    send_chk(devb(2'd0, 1'b0), 1'b1, "R2", "device ack");
    send_chk(8'h50, 1'b1, "R2", "word ack");
    do_stop();
    scl_m = 1'b0; wq();
    send_chk(8'hAB, 1'b0, "R2", "byte after stop");
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    chk(exp_q.size() == 0, "R4", "no pending writes", exp_q.size(), 0);
    chk(mem[10'h050] == gold[10'h050], "R2", "no store after stop", mem[10'h050], gold[10'h050]);
    report();
  end
endmodule